// File: doc/BRIEF.md
# Byte-Lane Data Store with Access Modes

This block is a small data store. Its address is 32 bits wide and names a single byte, and its data ports are 32 bits wide. A 2-bit operation code picks one of four accesses. The first reads a full word. The other three write a byte, a halfword or a full word, and each of these moves the write data onto the byte lanes chosen by the low address bits. Nothing happens while the enable is low.

Storage is organised as bytes, and a parameter sets the total size. Multi-byte values are laid out little-endian. Reads are combinational. Writes take effect on the rising clock edge. A halfword or word access whose address is not aligned raises an error flag and does not change storage. Any address above the configured size wraps modulo that size.

Top module: `lane_store`

## Requirements
- R1: Code 2'b00 with enable high reads the word at the address. Read data bits [8k+7:8k] hold the byte at the word base plus k, for k = 0 to 3. The read is combinational.
- R2: Code 2'b01 with enable high writes wr_data[7:0] to the addressed byte on the rising edge. The other bytes of that word do not change. Any address is allowed.
- R3: Code 2'b10 with enable high and addr[0]=0 writes wr_data[15:0] little-endian to the addressed byte and the next one. The other two bytes of the word do not change.
- R4: Code 2'b11 with enable high and addr[1:0]=0 writes all four bytes of wr_data little-endian.
- R5: With enable low, storage does not change and rd_data is zero.
- R6: A write code (01, 10 or 11) makes rd_data zero.
- R7: misalign is high exactly when enable is high and either the code is 10 with addr[0]=1, or the code is 00 or 11 with addr[1:0]≠0. A misaligned write leaves storage unchanged, and a misaligned read returns zero.
- R8: The address is taken modulo DEPTH bytes (default 1024). For example, 0x400 names the same byte as 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge |
| rst_n | input | 1 | Active-low reset (clears storage) |
| en | input | 1 | Access enable |
| op | input | 2 | Access code: 00 read word, 01 write byte, 10 write half, 11 write word |
| addr | input | 32 | Byte address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read word |
| misalign | output | 1 | Alignment fault flag |

## Verification
A write and an alignment fault can occur in the same cycle. The bench drives halfword and word writes at odd or unaligned addresses and checks that misalign is high in that cycle. After the edge it reads the whole word back and compares it with a model that ignored the write. Address wrap and lane placement also occur together: a byte write at DEPTH plus an offset must land in the lane of that offset inside the low word.

// File: rtl/lane_store.sv
module lane_store #(
  parameter int DEPTH = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [1:0]  op,
  input  logic [31:0] addr,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        misalign
);
  localparam int AW = $clog2(DEPTH);
  localparam int WORDS = DEPTH / 4;

  logic [7:0] mem [DEPTH];
  logic [AW-1:0] a;
  logic [AW-1:0] base;
  logic [3:0] lane_we;
  logic [31:0] lane_d;

  assign a = addr[AW-1:0];
  assign base = {a[AW-1:2], 2'b00};

  assign misalign = en && ((op == 2'b10 && addr[0]) ||
                           ((op == 2'b00 || op == 2'b11) && addr[1:0] != 2'b00));

  always_comb begin
    lane_we = 4'b0000;
    lane_d = '0;
    if (en && !misalign) begin
      case (op)
        2'b01: begin lane_we[addr[1:0]] = 1'b1; lane_d = {4{wr_data[7:0]}}; end
        2'b10: begin lane_we = addr[1] ? 4'b1100 : 4'b0011; lane_d = {2{wr_data[15:0]}}; end
        2'b11: begin lane_we = 4'b1111; lane_d = wr_data; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else begin
      for (int k = 0; k < 4; k++)
        if (lane_we[k]) mem[base + AW'(k)] <= lane_d[8*k +: 8];
    end
  end

  assign rd_data = (en && op == 2'b00 && !misalign) ?
                   {mem[base + AW'(3)], mem[base + AW'(2)], mem[base + AW'(1)], mem[base]} : 32'h0;

  p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> rd_data == 32'h0);
  p_write_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op != 2'b00) |-> rd_data == 32'h0);
  p_half_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 2'b10 && addr[0]) |-> misalign);
  p_idle_nofault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !misalign);
  p_byte_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'b01) |-> !misalign);
  p_word_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 2'b11 && addr[1:0] != 2'b00) |-> misalign);

  initial assert (WORDS * 4 == DEPTH && DEPTH >= 4);
endmodule

// File: tb/sim_lane_store.sv
module sim_lane_store;
  localparam int PERIOD = 10;
  logic clk = 0, rst_n = 0, en = 0;
  logic [1:0] op = 0;
  logic [31:0] addr = 0, wr_data = 0;
  logic [31:0] rd_data;
  logic misalign;
  int checks = 0, fails = 0;
  bit done = 0;

  lane_store u0 (.clk, .rst_n, .en, .op, .addr, .wr_data, .rd_data, .misalign);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] o, logic [31:0] a, logic [31:0] d);
    @(negedge clk); en = 1; op = o; addr = a; wr_data = d;
    @(negedge clk); en = 0; op = 0;
  endtask

  task automatic rd(logic [31:0] a, output logic [31:0] q);
    @(negedge clk); en = 1; op = 2'b00; addr = a; #1 q = rd_data;
    @(negedge clk); en = 0;
  endtask

  task automatic t_reset;
    logic [31:0] q;
    rd(32'h10, q); chk("R1 reset word", q, 32'h0);
    @(negedge clk); chk("R5 idle rd", rd_data, 0); chk("R7 idle flag", {31'b0, misalign}, 0);
  endtask

  task automatic t_word;
    logic [31:0] q;
    wr(2'b11, 32'h20, 32'hA1B2C3D4);
    rd(32'h20, q); chk("R4 word", q, 32'hA1B2C3D4);
    wr(2'b11, 32'h24, 32'h01020304);
    rd(32'h24, q); chk("R1 word2", q, 32'h01020304);
    rd(32'h20, q); chk("R4 neighbour", q, 32'hA1B2C3D4);
  endtask

  task automatic t_byte;
    logic [31:0] q;
    wr(2'b01, 32'h21, 32'hFFFF_FF55);
    rd(32'h20, q); chk("R2 lane1", q, 32'hA1B255D4);
    wr(2'b01, 32'h23, 32'h0000_0099);
    rd(32'h20, q); chk("R2 lane3", q, 32'h99B255D4);
  endtask

  task automatic t_half;
    logic [31:0] q;
    wr(2'b10, 32'h22, 32'hDEAD_BEEF);
    rd(32'h20, q); chk("R3 upper half", q, 32'hBEEF55D4);
    wr(2'b10, 32'h20, 32'h0000_1234);
    rd(32'h20, q); chk("R3 lower half", q, 32'hBEEF1234);
  endtask

  task automatic t_fault;
    logic [31:0] q;
    @(negedge clk); en = 1; op = 2'b10; addr = 32'h21; wr_data = 32'h7777;
    #1 chk("R7 half flag", {31'b0, misalign}, 1);
    @(negedge clk); op = 2'b11; addr = 32'h22; wr_data = 32'h66666666;
    #1 chk("R7 word flag", {31'b0, misalign}, 1);
    @(negedge clk); op = 2'b00; addr = 32'h23;
    #1 chk("R7 read flag", {31'b0, misalign}, 1); chk("R7 read zero", rd_data, 0);
    @(negedge clk); en = 0;
    rd(32'h20, q); chk("R7 unchanged", q, 32'hBEEF1234);
  endtask

  task automatic t_idle_and_modes;
    logic [31:0] q;
    @(negedge clk); en = 0; op = 2'b11; addr = 32'h20; wr_data = 32'h0BADF00D;
    @(negedge clk); rd(32'h20, q); chk("R5 no write", q, 32'hBEEF1234);
    @(negedge clk); en = 1; op = 2'b01; addr = 32'h20; wr_data = 32'h000000EE;
    #1 chk("R6 rd zero on write", rd_data, 0);
    @(negedge clk); en = 0;
  endtask

  task automatic t_wrap;
    logic [31:0] q;
    wr(2'b11, 32'h400, 32'hCAFEF00D);
    rd(32'h0, q); chk("R8 wrap word", q, 32'hCAFEF00D);
    wr(2'b01, 32'h0000_0402, 32'h11);
    rd(32'h400, q); chk("R8 wrap byte", q, 32'hCA11F00D);
  endtask

  initial begin
    #(PERIOD*3) rst_n = 1;
    t_reset; t_word; t_byte; t_half; t_fault; t_idle_and_modes; t_wrap;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin #(PERIOD*100000); fails++; checks++; $display("FAIL watchdog"); end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule